// File: doc/BRIEF.md
# Double-Buffer Transmit Admission Controller

This block arbitrates two fixed transmit buffers that a host-side writer fills and a device-side reader drains. Each side owns a free-running counter. The host side counts committed packets. The device side counts buffers it has finished reading. Both counters wrap modulo 16. Their difference is the number of buffers in use. A write may be committed only while fewer than two buffers are occupied.

The writer polls `space_ok` and fills the buffer named by `fill_idx`, which is the low bit of the input counter. It then pulses `wr_commit` with the packet's byte length. The block advances the input counter and holds the length, rounded up to a multiple of four bytes, on `commit_len`. It also raises `notify` for one cycle toward the device. The reader sees `buf_ready`, reads buffer `rd_idx` and pulses `rd_done` when it has finished.

A commit that arrives while both buffers are occupied is discarded and latches a sticky error flag. A read-complete pulse that arrives while no buffer is occupied is discarded.

Top module: `txdb_ctrl`

## Requirements
- R1: After synchronous reset, `in_count` and `out_count` are 0, `fill_idx` is 0, `notify`, `buf_ready` and `ovf_err` are 0, `commit_len` is 0 and `space_ok` is 1.
- R2: `space_ok` is 1 exactly when (`in_count` − `out_count`) mod 16 is less than 2. It follows the counters combinationally.
- R3: A `wr_commit` pulse accepted while `space_ok` is 1 increments `in_count` by one, modulo 16, at that clock edge.
- R4: `notify` is high for exactly the one cycle that follows each accepted commit, and is low otherwise.
- R5: `fill_idx` equals bit 0 of `in_count`, and `rd_idx` equals bit 0 of `out_count`. Buffers are therefore used in strict alternation starting with buffer 0.
- R6: A `rd_done` pulse while `buf_ready` is 1 increments `out_count` by one, modulo 16. A `rd_done` pulse while `buf_ready` is 0 leaves `out_count` unchanged.
- R7: On an accepted commit, `commit_len` takes `wr_len` rounded up to the next multiple of 4. It is one bit wider than `wr_len`, so 4095 becomes 4096. It holds that value until the next accepted commit.
- R8: A `wr_commit` pulse while `space_ok` is 0 leaves `in_count`, `commit_len` and `notify` unchanged. It sets `ovf_err`, which stays 1 until reset.
- R9: `buf_ready` is 1 exactly when (`in_count` − `out_count`) mod 16 is nonzero.
- R10: Both counters wrap from 15 to 0, and admission stays correct when the occupied buffers straddle that wrap.
- R11: An accepted commit and an accepted read in the same cycle both take effect, so the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_commit | input | 1 | Host has finished copying a packet (one-cycle pulse) |
| wr_len | input | 12 | Byte length of the packet being committed |
| rd_done | input | 1 | Device has finished reading a buffer (one-cycle pulse) |
| space_ok | output | 1 | A buffer is free for writing |
| fill_idx | output | 1 | Buffer the host should fill next |
| in_count | output | 4 | Committed-packet counter, modulo 16 |
| commit_len | output | 13 | Aligned length of the last accepted packet |
| notify | output | 1 | One-cycle pulse to the device per accepted packet |
| buf_ready | output | 1 | At least one buffer holds an unread packet |
| rd_idx | output | 1 | Buffer the device should read next |
| out_count | output | 4 | Completed-read counter, modulo 16 |
| ovf_err | output | 1 | Sticky flag: a commit arrived while both buffers were occupied |

## Verification
The hardest state to reach from the ports is a pair of occupied buffers whose counter values straddle the 15-to-0 wrap. Admission must then still be judged by a modulo-16 difference rather than by a plain magnitude comparison. The bench reaches this state by issuing same-cycle commit and read pairs, which advance both counters while keeping the occupancy at zero or one, until both counters sit at 15. It then commits twice, so that `in_count` wraps while `out_count` does not.

// File: rtl/txdb_pkg.sv
package txdb_pkg;
  localparam int DEF_CNT_W    = 4;
  localparam int DEF_CAPACITY = 2;
  localparam int DEF_LEN_W    = 12;
  localparam int DEF_ALIGN    = 4;
endpackage

// File: rtl/txdb_wrap_counter.sv
module txdb_wrap_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (inc) q <= q + 1'b1;
  end

  // R10: the counter rolls over from all-ones to zero
  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (inc && (q == {W{1'b1}})) |=> (q == '0));
endmodule

// File: rtl/txdb_admit.sv
module txdb_admit #(
  parameter int CNT_W    = 4,
  parameter int CAPACITY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] in_cnt,
  input  logic [CNT_W-1:0] out_cnt,
  input  logic             wr_commit,
  input  logic             rd_done,
  output logic             space_ok,
  output logic             buf_ready,
  output logic             commit_ok,
  output logic             read_ok,
  output logic             ovf_err
);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

  logic [CNT_W-1:0] occ;

  always_comb begin
    occ       = in_cnt - out_cnt;
    space_ok  = (occ < CAP_V);
    buf_ready = (occ != '0);
    commit_ok = wr_commit && space_ok;
    read_ok   = rd_done && buf_ready;
  end

  always_ff @(posedge clk) begin
    if (rst)                         ovf_err <= 1'b0;
    else if (wr_commit && !space_ok) ovf_err <= 1'b1;
  end

  // R2: the occupancy never exceeds the capacity
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
    occ <= CAP_V);

  // R8: once set, the error flag stays set
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
endmodule

// File: rtl/txdb_align.sv
module txdb_align #(
  parameter int LEN_W = 12,
  parameter int ALIGN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [LEN_W-1:0] len_in,
  output logic [LEN_W:0]   len_out
);
  localparam int OW = LEN_W + 1;
  localparam logic [OW-1:0] ROUND = OW'(ALIGN - 1);

  logic [OW-1:0] rounded;

  always_comb rounded = ({1'b0, len_in} + ROUND) & ~ROUND;

  always_ff @(posedge clk) begin
    if (rst)       len_out <= '0;
    else if (load) len_out <= rounded;
  end

  // R7: a loaded length is always a multiple of the alignment
  p_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    (len_out & ROUND) == '0);
endmodule

// File: rtl/txdb_ctrl.sv
module txdb_ctrl
  import txdb_pkg::*;
#(
  parameter int CNT_W    = DEF_CNT_W,
  parameter int CAPACITY = DEF_CAPACITY,
  parameter int LEN_W    = DEF_LEN_W,
  parameter int ALIGN    = DEF_ALIGN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_commit,
  input  logic [LEN_W-1:0] wr_len,
  input  logic             rd_done,
  output logic             space_ok,
  output logic             fill_idx,
  output logic [CNT_W-1:0] in_count,
  output logic [LEN_W:0]   commit_len,
  output logic             notify,
  output logic             buf_ready,
  output logic             rd_idx,
  output logic [CNT_W-1:0] out_count,
  output logic             ovf_err
);
  logic commit_ok;
  logic read_ok;

  txdb_wrap_counter #(.W(CNT_W)) in_ctr_i (
    .clk(clk), .rst(rst), .inc(commit_ok), .q(in_count)
  );

  txdb_wrap_counter #(.W(CNT_W)) out_ctr_i (
    .clk(clk), .rst(rst), .inc(read_ok), .q(out_count)
  );

  txdb_admit #(.CNT_W(CNT_W), .CAPACITY(CAPACITY)) admit_i (
    .clk(clk), .rst(rst),
    .in_cnt(in_count), .out_cnt(out_count),
    .wr_commit(wr_commit), .rd_done(rd_done),
    .space_ok(space_ok), .buf_ready(buf_ready),
    .commit_ok(commit_ok), .read_ok(read_ok),
    .ovf_err(ovf_err)
  );

  txdb_align #(.LEN_W(LEN_W), .ALIGN(ALIGN)) align_i (
    .clk(clk), .rst(rst), .load(commit_ok),
    .len_in(wr_len), .len_out(commit_len)
  );

  always_ff @(posedge clk) begin
    if (rst) notify <= 1'b0;
    else     notify <= commit_ok;
  end

  assign fill_idx = in_count[0];
  assign rd_idx   = out_count[0];

  // R4: every notify pulse matches one step of the input counter
  p_notify_r4: assert property (@(posedge clk) disable iff (rst)
    notify |-> (in_count == $past(in_count) + 1'b1));

  // R8: a commit while full changes neither the counter nor the length
  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && !space_ok) |=> ($stable(in_count) && $stable(commit_len) && ovf_err));

  // R6: a read pulse with nothing stored leaves the output counter alone
  p_rd_empty_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_done && !buf_ready) |=> $stable(out_count));

  // R11: a same-cycle accepted commit and read keep the occupancy
  p_simul_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && space_ok && rd_done && buf_ready) |=>
      ((in_count - out_count) == $past(in_count - out_count)));
endmodule

// File: tb/txdb_ctrl_tb.sv
module txdb_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_commit;
  logic [11:0] wr_len;
  logic        rd_done;
  logic        space_ok, fill_idx, notify, buf_ready, rd_idx, ovf_err;
  logic [3:0]  in_count, out_count;
  logic [12:0] commit_len;

  int checks = 0;
  int errors = 0;
  int exp_in = 0;
  int exp_out = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdb_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .wr_len(wr_len),
    .rd_done(rd_done), .space_ok(space_ok), .fill_idx(fill_idx),
    .in_count(in_count), .commit_len(commit_len), .notify(notify),
    .buf_ready(buf_ready), .rd_idx(rd_idx), .out_count(out_count),
    .ovf_err(ovf_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int occ();
    return (exp_in - exp_out) & 15;
  endfunction

  task automatic chk_state(input string req);
    chk({req, " in_count"}, int'(in_count), exp_in);
    chk({req, " out_count"}, int'(out_count), exp_out);
    chk({req, " space_ok (R2)"}, int'(space_ok), int'(occ() < 2));
    chk({req, " buf_ready (R9)"}, int'(buf_ready), int'(occ() != 0));
    chk({req, " fill_idx (R5)"}, int'(fill_idx), exp_in & 1);
    chk({req, " rd_idx (R5)"}, int'(rd_idx), exp_out & 1);
  endtask

  // One cycle: inputs driven at negedge, results sampled at the following negedge
  task automatic step(input bit c, input int len, input bit r);
    wr_commit = c;
    wr_len    = 12'(len);
    rd_done   = r;
    @(negedge clk);
    wr_commit = 1'b0;
    rd_done   = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; wr_commit = 1'b0; wr_len = '0; rd_done = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    exp_in = 0; exp_out = 0;
    chk_state("R1");
    chk("R1 notify", int'(notify), 0);
    chk("R1 ovf_err", int'(ovf_err), 0);
    chk("R1 commit_len", int'(commit_len), 0);
  endtask

  task automatic t_fill_and_full;
    step(1, 100, 0); exp_in++;
    chk_state("R3 first commit");
    chk("R4 notify after commit", int'(notify), 1);
    chk("R7 len 100", int'(commit_len), 100);
    step(0, 0, 0);
    chk("R4 notify drops", int'(notify), 0);
    step(1, 5, 0); exp_in++;
    chk_state("R3 second commit, full");
    chk("R7 len 5", int'(commit_len), 8);
    step(1, 9, 0);
    chk_state("R8 rejected commit");
    chk("R8 notify stays low", int'(notify), 0);
    chk("R8 len held", int'(commit_len), 8);
    chk("R8 ovf_err set", int'(ovf_err), 1);
  endtask

  task automatic t_read;
    step(0, 0, 1); exp_out++;
    chk_state("R6 first read");
    step(0, 0, 1); exp_out++;
    chk_state("R6 second read, empty");
    step(0, 0, 1);
    chk_state("R6 read while empty ignored");
    chk("R8 ovf_err sticky", int'(ovf_err), 1);
  endtask

  task automatic t_simul;
    step(1, 16, 0); exp_in++;
    step(1, 20, 1); exp_in++; exp_out++;
    chk_state("R11 commit and read together");
    chk("R11 notify", int'(notify), 1);
    chk("R11 len", int'(commit_len), 20);
    step(0, 0, 1); exp_out++;
    chk_state("R11 drained");
  endtask

  task automatic t_wrap;
    step(1, 4, 0); exp_in++;
    while (exp_in != 15) begin
      step(1, 4, 1); exp_in++; exp_out++;
    end
    step(0, 0, 1); exp_out++;
    chk_state("R10 both at 15");
    step(1, 4, 0); exp_in = 0;
    chk_state("R10 input wrapped");
    step(1, 4, 0); exp_in = 1;
    chk_state("R10 full across wrap");
    step(1, 4, 0);
    chk_state("R10 reject across wrap");
    step(0, 0, 1); exp_out = 0;
    chk_state("R10 output wrapped");
    step(0, 0, 1); exp_out = 1;
    chk_state("R10 empty after wrap");
  endtask

  task automatic t_len_corners;
    int lens[5] = '{0, 1, 4, 4093, 4095};
    int exps[5] = '{0, 4, 4, 4096, 4096};
    for (int i = 0; i < 5; i++) begin
      step(1, lens[i], 0); exp_in = (exp_in + 1) & 15;
      chk("R7 length rounding", int'(commit_len), exps[i]);
      step(0, 0, 1); exp_out = (exp_out + 1) & 15;
    end
    chk_state("R7 after length sweep");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_and_full();
    t_read();
    t_simul();
    t_wrap();
    t_len_corners();
    finish_run();
  end
endmodule